// File: doc/BRIEF.md
# Core Event Latch and Nesting Controller

This block sits between the event request lines of a processor core and its instruction sequencer. Each of up to sixteen event levels has a latch bit, a mask bit and a pending bit, held in 32-bit registers. A request sets its latch bit whether or not the level is masked. The block picks the lowest-numbered level that is latched, unmasked and enabled. It raises a request to the sequencer only when that level outranks every level already in service. The number of the winning level is presented alongside the request.

When the sequencer accepts, the latch bit of the winning level moves into the pending register in a single edge. A return-from-event pulse retires the innermost level in service, which is the lowest-numbered pending bit. The pending register therefore records the full nesting depth.

Software can do four things. It can read all three registers and write the mask. It can cancel latched events, but only on masked levels. It can gate the general-purpose levels, from level 7 upward, through a global enable that has separate set and clear commands.

Top module: `cec_core`

## Requirements
- R1: The latch, mask and pending registers read back as 32 bits. Bits at or above NUM_LEVELS (16) always read 0, and writes to them have no effect. Register addresses: 0 latch, 1 mask, 2 pending, 3 control (bit 0 is the global enable).
- R2: A high request line sets its latch bit on the next clock edge. Accepting the event clears that bit.
- R3: Writing a 1 to a latch bit cancels it only if its mask bit is 0. Latch bits whose mask bit is 1 are left unchanged. A request arriving in the same cycle as a cancel keeps the bit set.
- R4: A mask bit of 1 lets its level raise the request. A masked level still latches, but it never raises the request.
- R5: A pending bit is set from acceptance until its return. Writes to address 2 leave the pending register unchanged.
- R6: A set pulse turns the global enable on and a clear pulse turns it off. Clear wins if both pulses arrive together. The enable is 0 after reset.
- R7: Levels 0 to 6 ignore the global enable. Levels 7 to 15 can raise the request only while the enable is 1.
- R8: A lower level number has higher priority. The request is raised for the best eligible level only if that level is strictly lower in number than every pending level.
- R9: An accept pulse while the request is high clears the winning latch bit and sets its pending bit on the same edge. The winning level is output on irq_level_o.
- R10: A return pulse clears the lowest-numbered set pending bit. It has no effect when nothing is pending.
- R11: An accept pulse in the same cycle as a return pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_req_i | input | 16 | Event request lines, one per level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| gie_set_i | input | 1 | Global enable set command |
| gie_clr_i | input | 1 | Global enable clear command |
| ack_i | input | 1 | Sequencer accepts the presented event |
| ret_i | input | 1 | Return from the innermost event |
| irq_o | output | 1 | Event request to the sequencer |
| irq_level_o | output | 4 | Level number of the presented event |

## Verification
Each level is first raised on its own and carried through latch, accept and return. This separates the per-level datapath from the arbitration logic. Every pair of levels is then raised together, which shows whether the lower number always wins. The same pair sweep also shows that the losing level is held back while the winner is pending and is served after the return.

A sweep over all levels with the global enable cleared separates the ungated levels from the gated ones. Targeted sequences cover the remaining corner cases:
- nesting on top of an active level;
- a request at the same level as an active one;
- cancelling a masked latch versus an unmasked one;
- a write to the pending register;
- an accept pulse that coincides with a return.

// File: rtl/cec_pkg.sv
package cec_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LATCH = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_PEND  = 2'd2,
    ADDR_CTRL  = 2'd3
  } cec_addr_e;
endpackage

// File: rtl/cec_prio_enc.sv
module cec_prio_enc #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  // lowest index wins
  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
    onehot_o = '0;
    onehot_o[idx_o] = found_o;
  end
endmodule

// File: rtl/cec_latch_bank.sv
module cec_latch_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         latch_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] acc_clr_i,
  output logic [N-1:0] latch_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] latch_q, mask_q, sw_cancel;

  // cancel only where the level is masked
  assign sw_cancel = latch_we_i ? (wdata_i & ~mask_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= (latch_q & ~sw_cancel & ~acc_clr_i) | req_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign latch_o = latch_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/cec_pend_track.sv
module cec_pend_track #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     acc_set_i,
  input  logic             ret_i,
  output logic [N-1:0]     pend_o,
  output logic             top_found_o,
  output logic [IDX_W-1:0] top_idx_o
);
  logic [N-1:0] pend_q, top_oh;

  cec_prio_enc #(.N(N)) top_enc_i (
    .vec_i   (pend_q),
    .found_o (top_found_o),
    .idx_o   (top_idx_o),
    .onehot_o(top_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(ret_i ? top_oh : '0)) | acc_set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cec_arbiter.sv
module cec_arbiter #(
  parameter int unsigned N = 16,
  parameter int unsigned GP_BASE = 7,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     latch_i,
  input  logic [N-1:0]     mask_i,
  input  logic             gie_i,
  input  logic             top_found_i,
  input  logic [IDX_W-1:0] top_idx_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] lvl_o,
  output logic [N-1:0]     acc_oh_o
);
  logic [N-1:0] gate, cand, win_oh;
  logic         win_found;

  for (genvar g = 0; g < N; g++) begin : g_gate
    if (g < GP_BASE) begin : g_core
      assign gate[g] = 1'b1;
    end else begin : g_gp
      assign gate[g] = gie_i;
    end
  end

  assign cand = latch_i & mask_i & gate;

  cec_prio_enc #(.N(N)) win_enc_i (
    .vec_i   (cand),
    .found_o (win_found),
    .idx_o   (lvl_o),
    .onehot_o(win_oh)
  );

  assign irq_o    = win_found && (!top_found_i || (lvl_o < top_idx_i));
  assign acc_oh_o = (ack_i && irq_o && !ret_i) ? win_oh : '0;
endmodule

// File: rtl/cec_core.sv
module cec_core #(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned GP_BASE = 7,
  localparam int unsigned LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int unsigned REG_W = cec_pkg::REG_W,
  localparam int unsigned ADDR_W = cec_pkg::ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] evt_req_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic                  gie_set_i,
  input  logic                  gie_clr_i,
  input  logic                  ack_i,
  input  logic                  ret_i,
  output logic                  irq_o,
  output logic [LVL_W-1:0]      irq_level_o
);
  import cec_pkg::*;

  logic [NUM_LEVELS-1:0] latch_q, mask_q, pend_q, acc_oh;
  logic                  gie_q, top_found;
  logic [LVL_W-1:0]      top_idx;
  cec_addr_e             addr;

  assign addr = cec_addr_e'(reg_addr_i);

  cec_latch_bank #(.N(NUM_LEVELS)) bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (evt_req_i),
    .latch_we_i(reg_we_i && addr == ADDR_LATCH),
    .mask_we_i (reg_we_i && addr == ADDR_MASK),
    .wdata_i   (reg_wdata_i[NUM_LEVELS-1:0]),
    .acc_clr_i (acc_oh),
    .latch_o   (latch_q),
    .mask_o    (mask_q)
  );

  cec_pend_track #(.N(NUM_LEVELS)) pend_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_set_i  (acc_oh),
    .ret_i      (ret_i),
    .pend_o     (pend_q),
    .top_found_o(top_found),
    .top_idx_o  (top_idx)
  );

  cec_arbiter #(.N(NUM_LEVELS), .GP_BASE(GP_BASE)) arb_i (
    .latch_i    (latch_q),
    .mask_i     (mask_q),
    .gie_i      (gie_q),
    .top_found_i(top_found),
    .top_idx_i  (top_idx),
    .ack_i      (ack_i),
    .ret_i      (ret_i),
    .irq_o      (irq_o),
    .lvl_o      (irq_level_o),
    .acc_oh_o   (acc_oh)
  );

  // clear command dominates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gie_q <= 1'b0;
    else if (gie_clr_i) gie_q <= 1'b0;
    else if (gie_set_i) gie_q <= 1'b1;
  end

  always_comb begin
    unique case (addr)
      ADDR_LATCH: reg_rdata_o = REG_W'(latch_q);
      ADDR_MASK:  reg_rdata_o = REG_W'(mask_q);
      ADDR_PEND:  reg_rdata_o = REG_W'(pend_q);
      default:    reg_rdata_o = REG_W'(gie_q);
    endcase
  end
endmodule

// File: rtl/cec_core_chk.sv
module cec_core_chk #(
  parameter int unsigned NUM_LEVELS = 16,
  parameter int unsigned GP_BASE = 7,
  localparam int unsigned LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LEVELS-1:0] evt_req_i,
  input logic                  reg_we_i,
  input logic [1:0]            reg_addr_i,
  input logic                  ack_i,
  input logic                  ret_i,
  input logic                  irq_o,
  input logic [LVL_W-1:0]      irq_level_o,
  input logic [NUM_LEVELS-1:0] latch_q,
  input logic [NUM_LEVELS-1:0] mask_q,
  input logic [NUM_LEVELS-1:0] pend_q,
  input logic                  gie_q
);
  logic                  acc_fire;
  logic [NUM_LEVELS-1:0] at_or_above;

  assign acc_fire = ack_i && irq_o && !ret_i;

  always_comb begin
    for (int i = 0; i < NUM_LEVELS; i++) at_or_above[i] = (i <= int'(irq_level_o));
  end

  AST_IRQ_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (latch_q[irq_level_o] && mask_q[irq_level_o])); // R4
  AST_PRIO_OVER_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_q & at_or_above) == '0)); // R8
  AST_GIE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !gie_q) |-> (int'(irq_level_o) < GP_BASE)); // R7
  AST_ACCEPT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fire && !evt_req_i[irq_level_o]) |=>
      (pend_q[$past(irq_level_o)] && !latch_q[$past(irq_level_o)])); // R9
  AST_RET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && pend_q != '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R10
  AST_PEND_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2 && !acc_fire && !ret_i) |=> $stable(pend_q)); // R5
endmodule

bind cec_core cec_core_chk #(.NUM_LEVELS(NUM_LEVELS), .GP_BASE(GP_BASE)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_req_i  (evt_req_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .ack_i      (ack_i),
  .ret_i      (ret_i),
  .irq_o      (irq_o),
  .irq_level_o(irq_level_o),
  .latch_q    (latch_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q),
  .gie_q      (gie_q)
);

// File: tb/cec_core_tb.sv
module cec_core_tb_top;
  localparam int unsigned N = 16;
  localparam int unsigned GPB = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt_req = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        gie_set = 1'b0, gie_clr = 1'b0, ack = 1'b0, ret = 1'b0;
  logic        irq;
  logic [3:0]  irq_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cec_core #(.NUM_LEVELS(N), .GP_BASE(GPB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_req_i(evt_req),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .gie_set_i(gie_set), .gie_clr_i(gie_clr),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .irq_level_o(irq_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic raise(input logic [N-1:0] v);
    evt_req = v; tick(); evt_req = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    rd(2'd0, d); chk("R2 reset latch", d, 0);
    rd(2'd1, d); chk("R4 reset mask", d, 0);
    rd(2'd2, d); chk("R5 reset pend", d, 0);
    rd(2'd3, d); chk("R6 reset gie", d, 0);
    chk("R8 reset irq", 32'(irq), 0);

    // R1 upper bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R1 mask width", d, 32'h0000_FFFF);

    // R6 commands
    gie_set = 1'b1; tick(); gie_set = 1'b0;
    rd(2'd3, d); chk("R6 set", d, 1);
    gie_set = 1'b1; gie_clr = 1'b1; tick(); gie_set = 1'b0; gie_clr = 1'b0;
    rd(2'd3, d); chk("R6 clear wins", d, 0);
    gie_set = 1'b1; tick(); gie_set = 1'b0;
    rd(2'd3, d); chk("R6 set again", d, 1);

    // single-level sweep
    for (int l = 0; l < N; l++) begin
      raise(N'(1) << l);
      rd(2'd0, d); chk("R2 latch set", d, 32'(1) << l);
      chk("R9 irq", 32'(irq), 1);
      chk("R9 level", 32'(irq_level), 32'(l));
      do_ack();
      rd(2'd0, d); chk("R9 latch cleared", d, 0);
      rd(2'd2, d); chk("R9 pend set", d, 32'(1) << l);
      chk("R9 irq drop", 32'(irq), 0);
      do_ret();
      rd(2'd2, d); chk("R10 pend cleared", d, 0);
    end

    // pair sweep
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        raise((N'(1) << a) | (N'(1) << b));
        chk("R8 pair winner", 32'(irq_level), 32'(a));
        do_ack();
        chk("R8 loser held", 32'(irq), 0);
        do_ret();
        chk("R8 loser next", {31'(irq), irq_level}, {31'(1), 4'(b)});
        do_ack();
        do_ret();
      end
    end

    // nesting
    raise(N'(1) << 10); do_ack();
    raise(N'(1) << 12);
    chk("R8 lower blocked", 32'(irq), 0);
    raise(N'(1) << 4);
    chk("R8 nest level", {31'(irq), irq_level}, {31'(1), 4'd4});
    do_ack();
    rd(2'd2, d); chk("R5 nested pend", d, 32'h0000_0410);
    rd(2'd0, d); chk("R2 held latch", d, 32'h0000_1000);
    do_ret();
    rd(2'd2, d); chk("R10 pops innermost", d, 32'h0000_0400);
    chk("R8 still blocked", 32'(irq), 0);
    do_ret();
    chk("R8 served after", {31'(irq), irq_level}, {31'(1), 4'd12});
    do_ack();
    raise(N'(1) << 12);
    chk("R8 equal blocked", 32'(irq), 0);
    do_ret();
    chk("R8 equal served", {31'(irq), irq_level}, {31'(1), 4'd12});
    do_ack(); do_ret();
    do_ret();
    rd(2'd2, d); chk("R10 empty ret", d, 0);

    // mask and cancel
    wr(2'd1, 32'h0);
    raise(N'(1) << 3);
    rd(2'd0, d); chk("R4 masked latches", d, 32'h8);
    chk("R4 masked no irq", 32'(irq), 0);
    wr(2'd0, 32'h8);
    rd(2'd0, d); chk("R3 cancel masked", d, 0);
    raise(N'(1) << 3);
    evt_req = N'(8); wr(2'd0, 32'h8); evt_req = '0;
    rd(2'd0, d); chk("R3 request wins", d, 32'h8);
    wr(2'd1, 32'h8);
    chk("R4 unmask irq", {31'(irq), irq_level}, {31'(1), 4'd3});
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R3 unmasked kept", d, 32'h8);
    do_ack();
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R5 pend read only", d, 32'h8);
    do_ret();

    // gate sweep
    wr(2'd1, 32'hFFFF);
    gie_clr = 1'b1; tick(); gie_clr = 1'b0;
    for (int l = 0; l < N; l++) begin
      raise(N'(1) << l);
      chk("R7 gate", 32'(irq), (l < GPB) ? 1 : 0);
      if (l < GPB) begin
        chk("R7 level", 32'(irq_level), 32'(l));
        do_ack(); do_ret();
      end else begin
        wr(2'd1, 32'h0); wr(2'd0, 32'(1) << l); wr(2'd1, 32'hFFFF);
      end
    end
    raise(N'(1) << 9);
    chk("R7 gated", 32'(irq), 0);
    gie_set = 1'b1; tick(); gie_set = 1'b0;
    chk("R6 enable opens", {31'(irq), irq_level}, {31'(1), 4'd9});
    do_ack(); do_ret();

    // R11 ack with ret
    raise(N'(1) << 2);
    ack = 1'b1; ret = 1'b1; tick(); ack = 1'b0; ret = 1'b0;
    rd(2'd0, d); chk("R11 latch kept", d, 32'h4);
    rd(2'd2, d); chk("R11 pend empty", d, 0);
    do_ack(); do_ret();
    rd(2'd2, d); chk("R10 final pend", d, 0);

    finish_run();
  end
endmodule